// File: doc/BRIEF.md
# Interrupt Request Front End

This block sits between a processor's interrupt sources and its instruction sequencer. Once per processor cycle, marked by a cycle enable, it samples the non-maskable interrupt level. It latches a request when it sees a low-to-high transition. It also keeps an 8-bit mask of level-sensitive maskable requests, which the sources raise and drop through per-bit set and clear strobes. The mask is gated by the interrupt-disable flag.

Both the non-maskable request and the gated maskable state pass through one register stage before the sequencer sees them. A one-shot lock strobe holds that stage for one update, for example while the sequencer is in a span that must not see a new interrupt. An acknowledge from the sequencer retires the non-maskable request.

Top module: `irq_front`

## Requirements
- R1: While reset is asserted and after it is released, `nmi_pend_o`, `irq_pend_o` and `irq_src_o` are all zero, and the sampled level history is low.
- R2: When the level sampled on one enabled cycle is low and the level sampled on the next enabled cycle is high, a request is latched at that clock edge. It appears on `nmi_pend_o` at the next enabled clock edge.
- R3: A level that stays high produces no further request after the first one is acknowledged.
- R4: A latched request stays on `nmi_pend_o` until it is acknowledged.
- R5: `nmi_ack_i` clears both the latched request and `nmi_pend_o` at the clock edge where it is sampled, whether or not the cycle is enabled. A new edge detected in that same cycle is kept as a latched request.
- R6: At each enabled update, `irq_pend_o` takes the value (any bit of `irq_src_o` set) AND NOT `irq_dis_i`. A change in the mask therefore reaches `irq_pend_o` one update later.
- R7: On every clock edge, enabled or not, a set strobe bit ORs its mask bit in, and a clear strobe bit removes only its own mask bit. Bit i of the strobes acts on bit i of `irq_src_o`.
- R8: If set and clear name the same bit in one cycle, that bit ends up set.
- R9: After `lock_i` is seen, the next enabled update leaves both pending outputs unchanged. The lock then clears itself, so the update after that proceeds normally. Cycles without the enable neither consume nor clear the lock.
- R10: When `cyc_en_i` is low, the level is not sampled and the pending outputs do not change (except through R5). A high pulse that begins and ends within disabled cycles is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Processor cycle enable; sampling and pending updates occur only when high |
| nmi_lvl_i | input | 1 | Non-maskable request level |
| irq_set_i | input | 8 | Per-source set strobes for the maskable mask |
| irq_clr_i | input | 8 | Per-source clear strobes for the maskable mask |
| irq_dis_i | input | 1 | Interrupt-disable flag |
| lock_i | input | 1 | Freeze the next pending update |
| nmi_ack_i | input | 1 | Non-maskable request acknowledge |
| nmi_pend_o | output | 1 | Registered non-maskable pending |
| irq_pend_o | output | 1 | Registered maskable pending |
| irq_src_o | output | 8 | Current source mask |

## Verification
The hardest states to reach are those where the pending stage and its inputs disagree. One is a lock taken in the same cycle that the mask first becomes non-zero. There, a frozen stage and an unfrozen stage differ only in the single update that follows. The stimulus sets a source and asserts the lock together. It then inserts disabled cycles before the next enabled one, which shows that the lock waits for a real update rather than expiring on the clock. A short non-maskable pulse placed entirely inside disabled cycles checks that sampling follows the enable and not the clock.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int unsigned SRC_W = 8;
  typedef logic [SRC_W-1:0] src_mask_t;

  typedef struct packed {
    logic nmi;
    logic irq;
  } pend_t;
endpackage

// File: rtl/nmi_edge_det.sv
module nmi_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_en_i,
  input  logic nmi_lvl_i,
  input  logic nmi_ack_i,
  output logic nmi_req_o
);
  logic prev_q, req_q;
  logic edge_seen;

  assign edge_seen = cyc_en_i && !prev_q && nmi_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (cyc_en_i) prev_q <= nmi_lvl_i;
      // a fresh edge survives a coincident acknowledge
      if (edge_seen)      req_q <= 1'b1;
      else if (nmi_ack_i) req_q <= 1'b0;
    end
  end

  assign nmi_req_o = req_q;

  // R2
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_en_i && !prev_q && nmi_lvl_i |=> nmi_req_o);
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o && !nmi_ack_i |=> nmi_req_o);
  // R10
  no_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_i |=> $stable(prev_q));
endmodule

// File: rtl/irq_src_mask.sv
module irq_src_mask
  import irqf_pkg::*;
#(
  parameter int unsigned W = SRC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] src_o,
  output logic         any_o
);
  logic [W-1:0] src_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       src_q[b] <= 1'b0;
      else if (set_i[b]) src_q[b] <= 1'b1;
      else if (clr_i[b]) src_q[b] <= 1'b0;
    end
  end

  assign src_o = src_q;
  assign any_o = |src_q;

  // R7 R8
  set_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((src_o & $past(set_i)) == $past(set_i)));
  // R7
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((src_o & $past(clr_i & ~set_i)) == '0));
  // R7
  untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((src_o & ~$past(set_i | clr_i)) == ($past(src_o) & ~$past(set_i | clr_i))));
endmodule

// File: rtl/pend_stage.sv
module pend_stage
  import irqf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cyc_en_i,
  input  logic  lock_i,
  input  logic  nmi_ack_i,
  input  logic  nmi_req_i,
  input  logic  irq_any_i,
  input  logic  irq_dis_i,
  output pend_t pend_o
);
  pend_t pend_q;
  logic  lock_q;
  logic  upd;

  assign upd = cyc_en_i && !lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lock_q <= 1'b0;
    else if (lock_i)   lock_q <= 1'b1;
    else if (cyc_en_i) lock_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      if (nmi_ack_i)  pend_q.nmi <= 1'b0;
      else if (upd)   pend_q.nmi <= nmi_req_i;
      if (upd)        pend_q.irq <= irq_any_i && !irq_dis_i;
    end
  end

  assign pend_o = pend_q;

  // R5
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_ack_i |=> !pend_o.nmi);
  // R9
  lock_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && cyc_en_i && !nmi_ack_i |=> $stable(pend_o));
  // R9
  lock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && cyc_en_i && !lock_i |=> !lock_q);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_i && !nmi_ack_i |=> $stable(pend_o));
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irqf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_en_i,
  input  logic             nmi_lvl_i,
  input  logic [SRC_W-1:0] irq_set_i,
  input  logic [SRC_W-1:0] irq_clr_i,
  input  logic             irq_dis_i,
  input  logic             lock_i,
  input  logic             nmi_ack_i,
  output logic             nmi_pend_o,
  output logic             irq_pend_o,
  output logic [SRC_W-1:0] irq_src_o
);
  logic  nmi_req;
  logic  irq_any;
  pend_t pend;

  nmi_edge_det u_edge (
    .clk_i, .rst_ni, .cyc_en_i, .nmi_lvl_i, .nmi_ack_i,
    .nmi_req_o (nmi_req)
  );

  irq_src_mask #(.W(SRC_W)) u_mask (
    .clk_i, .rst_ni,
    .set_i (irq_set_i),
    .clr_i (irq_clr_i),
    .src_o (irq_src_o),
    .any_o (irq_any)
  );

  pend_stage u_pend (
    .clk_i, .rst_ni, .cyc_en_i, .lock_i, .nmi_ack_i,
    .nmi_req_i (nmi_req),
    .irq_any_i (irq_any),
    .irq_dis_i,
    .pend_o    (pend)
  );

  assign nmi_pend_o = pend.nmi;
  assign irq_pend_o = pend.irq;

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!nmi_pend_o && !irq_pend_o && irq_src_o == '0));
endmodule

// File: tb/irq_front_tb.sv
module irq_front_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_en_i = 1'b0, nmi_lvl_i = 1'b0, irq_dis_i = 1'b0;
  logic       lock_i = 1'b0, nmi_ack_i = 1'b0;
  logic [7:0] irq_set_i = '0, irq_clr_i = '0;
  logic       nmi_pend_o, irq_pend_o;
  logic [7:0] irq_src_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic       nmi;
    logic       irq;
    logic [7:0] src;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk_i = ~clk_i;

  irq_front u_dut (.*);

  // monitor: compare after each edge
  always @(posedge clk_i) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (nmi_pend_o !== e.nmi || irq_pend_o !== e.irq || irq_src_o !== e.src) begin
        failures++;
        $display("FAIL %s: got nmi=%b irq=%b src=%h exp nmi=%b irq=%b src=%h",
                 e.tag, nmi_pend_o, irq_pend_o, irq_src_o, e.nmi, e.irq, e.src);
      end
    end
  end

  task automatic drv(input logic en, input logic nmi, input logic [7:0] st,
                     input logic [7:0] cl, input logic dis, input logic lk,
                     input logic ack, input logic en_n, input logic en_i,
                     input logic [7:0] en_s, input string tag);
    @(negedge clk_i);
    cyc_en_i = en; nmi_lvl_i = nmi; irq_set_i = st; irq_clr_i = cl;
    irq_dis_i = dis; lock_i = lk; nmi_ack_i = ack;
    sb_q.push_back('{en_n, en_i, en_s, tag});
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog: got hang exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #9;
    checks++;
    if (nmi_pend_o !== 1'b0 || irq_pend_o !== 1'b0 || irq_src_o !== 8'h00) begin
      failures++;
      $display("FAIL R1: got nmi=%b irq=%b src=%h exp 0 0 00", nmi_pend_o, irq_pend_o, irq_src_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    //   en nmi set    clr    dis lk ack  n  i  src
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R1 idle after reset");
    drv(1, 1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R2 edge latched, not yet pending");
    drv(1, 1, 8'h00, 8'h00, 0, 0, 0, 1, 0, 8'h00, "R2 pending one update later");
    drv(1, 1, 8'h00, 8'h00, 0, 0, 0, 1, 0, 8'h00, "R4 hold");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 1, 0, 8'h00, "R4 hold after level drop");
    drv(1, 1, 8'h00, 8'h00, 0, 0, 1, 0, 0, 8'h00, "R5 ack with new edge clears pend");
    drv(1, 1, 8'h00, 8'h00, 0, 0, 0, 1, 0, 8'h00, "R5 coincident edge kept");
    drv(1, 1, 8'h00, 8'h00, 0, 0, 1, 0, 0, 8'h00, "R5 ack clears");
    drv(1, 1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R3 high level no new request");
    drv(1, 1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R3 high level no new request 2");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R10 low sampled");
    drv(0, 1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R10 pulse in disabled cycle");
    drv(0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R10 pulse ends disabled");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R10 hidden pulse ignored");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R10 hidden pulse ignored 2");
    drv(1, 1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R2 edge");
    drv(0, 1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R10 no update while disabled");
    drv(1, 1, 8'h00, 8'h00, 0, 0, 0, 1, 0, 8'h00, "R2 pend at next enabled edge");
    drv(0, 1, 8'h00, 8'h00, 0, 0, 1, 0, 0, 8'h00, "R5 ack while disabled");
    drv(1, 0, 8'h05, 8'h00, 0, 0, 0, 0, 0, 8'h05, "R7 set ORs in");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 8'h05, "R6 irq one update later");
    drv(1, 0, 8'h00, 8'h01, 0, 0, 0, 0, 1, 8'h04, "R7 clear only named bit");
    drv(1, 0, 8'h00, 8'h00, 1, 0, 0, 0, 0, 8'h04, "R6 disable masks");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 8'h04, "R6 enable again");
    drv(1, 0, 8'h00, 8'h04, 0, 0, 0, 0, 1, 8'h00, "R6 uses mask before clear");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R6 empty mask");
    drv(0, 0, 8'h81, 8'h81, 0, 0, 0, 0, 0, 8'h81, "R8 set wins, R7 mask moves while disabled");
    drv(1, 0, 8'h02, 8'h80, 0, 0, 0, 0, 1, 8'h03, "R8 R7 mixed strobes");
    drv(1, 0, 8'h00, 8'h03, 0, 0, 0, 0, 1, 8'h00, "R7 clear remaining");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, "R6 cleared");
    drv(1, 0, 8'h10, 8'h00, 0, 1, 0, 0, 0, 8'h10, "R9 lock taken with set");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h10, "R9 frozen update");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 8'h10, "R9 lock self-cleared");
    drv(1, 0, 8'h00, 8'h10, 0, 0, 0, 0, 1, 8'h00, "R7 clear");
    drv(1, 0, 8'h20, 8'h00, 0, 1, 0, 0, 0, 8'h20, "R9 lock again");
    drv(0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h20, "R9 disabled cycle keeps lock");
    drv(0, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h20, "R9 disabled cycle keeps lock 2");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h20, "R9 lock consumed here");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 8'h20, "R9 normal update after");
    drv(1, 0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 8'h20, "R6 steady");
    @(negedge clk_i);
    cyc_en_i = 1'b0; irq_set_i = '0; irq_clr_i = '0; lock_i = 1'b0; nmi_ack_i = 1'b0;
    repeat (3) @(negedge clk_i);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: got %0d left exp 0", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule